// File: doc/BRIEF.md
# Reconfigurable ALU-Shift Functional Unit

This block is one basic functional unit of a custom-instruction accelerator that sits next to a processor pipeline. In a single cycle it applies an arithmetic or logic operation to two operands and passes the result through a shifter. The arithmetic/logic stage can be skipped so that a shift can be done alone. A configuration word chooses every part of that path. It picks where each of the two operands comes from: a register-file value, the complex unit's result, the neighbouring basic unit's result, or this unit's own registered result. It also picks the ALU operation, the kind of shift, and whether the shift amount comes from a constant in the configuration or from the data.

The combinational result can be used in the same cycle by other units of the fabric. A local result register captures it on every enabled time step, so a configuration in the next time step can feed the value back into either operand. Configuration storage, sequencing and the register file are outside this block. The configuration and data inputs are plain levels that a sequencer holds stable for a time step, so the block has no handshake.

Top module: `recon_alu_shift_unit`

## Requirements
- R1: Operand A is chosen by `cfg_src_a`: 00 selects `rf_a`, 01 selects `cplx_res`, 10 selects `nbr_res`, 11 selects `result_q`.
- R2: Operand B is chosen by `cfg_src_b` with the same codes, except that code 00 selects `rf_b`.
- R3: `cfg_alu_op` 000 gives A+B and 001 gives A-B. Both wrap modulo 2^32.
- R4: `cfg_alu_op` 010 gives A AND B, 011 gives A OR B, 100 gives A XOR B, and 101 gives NOT A (the bitwise complement of A, with B ignored).
- R5: `cfg_alu_op` 110 passes A to the shifter unchanged. Code 111 gives zero.
- R6: `cfg_shift_kind` 00 applies no shift, 01 is a logical left shift, 10 is a logical right shift, and 11 is an arithmetic right shift that fills with bit 31 of the ALU output.
- R7: When `cfg_amt_from_data` is 0, the shift amount is `cfg_amt_const`. When it is 1, the shift amount is bits 4:0 of operand B.
- R8: The shift is applied to the ALU output, and `result` reflects the current inputs in the same cycle, with no register on the path.
- R9: At a rising clock edge with `step_en` high, `result_q` loads `result`. With `step_en` low it keeps its value.
- R10: A synchronous active-high `rst` clears `result_q` to zero and takes priority over `step_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Time-step enable for the feedback register |
| cfg_src_a | input | 2 | Operand A source select |
| cfg_src_b | input | 2 | Operand B source select |
| cfg_alu_op | input | 3 | ALU operation code |
| cfg_shift_kind | input | 2 | Shift kind |
| cfg_amt_from_data | input | 1 | Shift-amount source: 1 = operand B, 0 = constant |
| cfg_amt_const | input | 5 | Constant shift amount |
| rf_a | input | 32 | Register-file operand A |
| rf_b | input | 32 | Register-file operand B |
| cplx_res | input | 32 | Complex unit result |
| nbr_res | input | 32 | Neighbouring basic unit result |
| result | output | 32 | Combinational unit result |
| result_q | output | 32 | Registered result used for feedback |

## Verification
The source selectors are swept over all sixteen pairs with subtraction, which is not commutative. Each of the four inputs carries a distinct value, so a swapped or miswired source shows up as a wrong difference. The ALU and shifter are then swept over every opcode, every shift kind and both amount sources. The data patterns are chosen to tell the operations apart: patterns with the sign bit set separate arithmetic from logical right shifts, carry-producing sums expose wrap errors, and differing B values separate NOT and bypass from the two-operand operations. Shift constants of 0, 1, 13 and 31 exercise both ends of the amount range. A final sequence alternates the enable and applies reset, to show when the feedback register loads, when it holds, and that it clears.

// File: rtl/recon_fu_pkg.sv
package recon_fu_pkg;
  typedef enum logic [1:0] {
    SRC_RF   = 2'b00,
    SRC_CPLX = 2'b01,
    SRC_NBR  = 2'b10,
    SRC_SELF = 2'b11
  } src_sel_e;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_XOR  = 3'b100,
    OP_NOT  = 3'b101,
    OP_PASS = 3'b110,
    OP_ZERO = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_SLL  = 2'b01,
    SH_SRL  = 2'b10,
    SH_SRA  = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/fu_operand_mux.sv
module fu_operand_mux
  import recon_fu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] cplx_val,
  input  logic [DATA_W-1:0] nbr_val,
  input  logic [DATA_W-1:0] self_val,
  output logic [DATA_W-1:0] opnd
);
  always_comb begin
    unique case (src_sel_e'(sel))
      SRC_RF:   opnd = rf_val;
      SRC_CPLX: opnd = cplx_val;
      SRC_NBR:  opnd = nbr_val;
      default:  opnd = self_val;
    endcase
  end
endmodule

// File: rtl/fu_alu.sv
module fu_alu
  import recon_fu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (alu_op_e'(op))
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_PASS: y = a;
      default: y = '0;
    endcase
  end

  // Sum and difference must invert each other modulo 2^DATA_W (R3)
  always_comb begin
    if (op == OP_ADD && !$isunknown({a, b}))
      assert_add_inverts_R3: assert (DATA_W'(y - b) == a);
    if (op == OP_SUB && !$isunknown({a, b}))
      assert_sub_inverts_R3: assert (DATA_W'(y + b) == a);
  end
endmodule

// File: rtl/fu_shifter.sv
module fu_shifter
  import recon_fu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [1:0]        kind,
  input  logic [SH_W-1:0]   amt,
  input  logic [DATA_W-1:0] x,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (shift_kind_e'(kind))
      SH_NONE: y = x;
      SH_SLL:  y = x << amt;
      SH_SRL:  y = x >> amt;
      default: y = DATA_W'($signed(x) >>> amt);
    endcase
  end

  // A right shift moves no set bit upward: the population count never grows (R6)
  always_comb begin
    if (kind == SH_SRL && !$isunknown({x, amt}))
      assert_srl_no_growth_R6: assert ($countones(y) <= $countones(x));
  end
endmodule

// File: rtl/recon_alu_shift_unit.sv
module recon_alu_shift_unit
  import recon_fu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic [1:0]        cfg_src_a,
  input  logic [1:0]        cfg_src_b,
  input  logic [2:0]        cfg_alu_op,
  input  logic [1:0]        cfg_shift_kind,
  input  logic              cfg_amt_from_data,
  input  logic [SH_W-1:0]   cfg_amt_const,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [DATA_W-1:0] cplx_res,
  input  logic [DATA_W-1:0] nbr_res,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] result_q
);
  localparam int N_OPND = 2;

  logic [DATA_W-1:0] rf_vals [N_OPND];
  logic [1:0]        sels    [N_OPND];
  logic [DATA_W-1:0] opnds   [N_OPND];
  logic [DATA_W-1:0] alu_y;
  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] fb_q;

  assign rf_vals[0] = rf_a;
  assign rf_vals[1] = rf_b;
  assign sels[0]    = cfg_src_a;
  assign sels[1]    = cfg_src_b;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    fu_operand_mux #(.DATA_W(DATA_W)) i_mux (
      .sel      (sels[g]),
      .rf_val   (rf_vals[g]),
      .cplx_val (cplx_res),
      .nbr_val  (nbr_res),
      .self_val (fb_q),
      .opnd     (opnds[g])
    );
  end

  fu_alu #(.DATA_W(DATA_W)) i_alu (
    .op (cfg_alu_op),
    .a  (opnds[0]),
    .b  (opnds[1]),
    .y  (alu_y)
  );

  assign shamt = cfg_amt_from_data ? opnds[1][SH_W-1:0] : cfg_amt_const;

  fu_shifter #(.DATA_W(DATA_W)) i_shift (
    .kind (cfg_shift_kind),
    .amt  (shamt),
    .x    (alu_y),
    .y    (result)
  );

  always_ff @(posedge clk) begin
    if (rst)          fb_q <= '0;
    else if (step_en) fb_q <= result;
  end

  assign result_q = fb_q;

  // Cross-stage checks
  always_comb begin
    if (!rst && !$isunknown({cfg_alu_op, cfg_shift_kind, opnds[0], result})) begin
      if (cfg_alu_op == OP_PASS && cfg_shift_kind == SH_NONE)
        assert_bypass_chain_R5: assert (result == opnds[0]);
      if (cfg_src_a == SRC_SELF)
        assert_self_feed_R1: assert (opnds[0] == fb_q);
    end
  end

  assert_fb_load_R9: assert property (@(posedge clk) disable iff (rst)
    step_en |=> result_q == $past(result));

  assert_fb_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rst && !step_en |=> $stable(result_q));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> result_q == '0);
endmodule

// File: tb/test_recon_alu_shift_unit.sv
module test_recon_alu_shift_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         step_en = 1'b0;
  logic [1:0]   cfg_src_a = '0, cfg_src_b = '0, cfg_shift_kind = '0;
  logic [2:0]   cfg_alu_op = '0;
  logic         cfg_amt_from_data = 1'b0;
  logic [4:0]   cfg_amt_const = '0;
  logic [W-1:0] rf_a = '0, rf_b = '0, cplx_res = '0, nbr_res = '0;
  logic [W-1:0] result, result_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  recon_alu_shift_unit i_recon_alu_shift_unit (
    .clk, .rst, .step_en, .cfg_src_a, .cfg_src_b, .cfg_alu_op,
    .cfg_shift_kind, .cfg_amt_from_data, .cfg_amt_const,
    .rf_a, .rf_b, .cplx_res, .nbr_res, .result, .result_q
  );

  function automatic logic [W-1:0] pick(input logic [1:0] s, input logic [W-1:0] rfv,
                                        input logic [W-1:0] q);
    case (s)
      2'd0: return rfv;
      2'd1: return cplx_res;
      2'd2: return nbr_res;
      default: return q;
    endcase
  endfunction

  function automatic logic [W-1:0] model_alu(input logic [2:0] op, input logic [W-1:0] a,
                                             input logic [W-1:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a + (~b + 1);
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a ^ {W{1'b1}};
      3'd6: return a;
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] model_shift(input logic [1:0] k, input int n,
                                               input logic [W-1:0] x);
    logic [W-1:0] ones;
    ones = {W{1'b1}};
    case (k)
      2'd0: return x;
      2'd1: return x * (64'd1 << n);
      2'd2: return x / (64'd1 << n);
      default: return (x / (64'd1 << n)) | (x[W-1] ? ~(ones / (64'd1 << n)) : '0);
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    logic [W-1:0] pats [6];
    logic [W-1:0] q_model;
    int consts [4];
    pats[0] = 32'h0000_0001; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h8000_0000;
    pats[3] = 32'h1234_5678; pats[4] = 32'hC3A5_0F1E; pats[5] = 32'h7FFF_FFFF;
    consts[0] = 0; consts[1] = 1; consts[2] = 13; consts[3] = 31;

    repeat (2) @(negedge clk);
    check("R10 reset value", result_q, '0);
    rst = 1'b0;

    // Load a known feedback value: bypass rf_a, no shift
    rf_a = 32'h0000_5000; cfg_src_a = 2'd0; cfg_alu_op = 3'd6; cfg_shift_kind = 2'd0;
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    q_model = 32'h0000_5000;
    check("R9 load", result_q, q_model);

    // Source sweep with subtraction (R1, R2)
    rf_a = 32'h0000_0100; rf_b = 32'h0000_0020; cplx_res = 32'h0003_0000; nbr_res = 32'h0040_0000;
    cfg_alu_op = 3'd1;
    for (int sa = 0; sa < 4; sa++) begin
      for (int sb = 0; sb < 4; sb++) begin
        cfg_src_a = 2'(sa); cfg_src_b = 2'(sb);
        #2;
        check("R1/R2 source select", result,
              pick(2'(sa), rf_a, q_model) - pick(2'(sb), rf_b, q_model));
        @(negedge clk);
      end
    end

    // ALU x shifter sweep (R3..R8)
    cfg_src_a = 2'd0; cfg_src_b = 2'd0;
    for (int op = 0; op < 8; op++) begin
      for (int k = 0; k < 4; k++) begin
        for (int ad = 0; ad < 2; ad++) begin
          for (int p = 0; p < 6; p++) begin
            for (int c = 0; c < 4; c++) begin
              logic [W-1:0] av, bv, y;
              int n;
              string tag;
              av = pats[p]; bv = pats[(p + 3) % 6] + 32'(c);
              rf_a = av; rf_b = bv;
              cfg_alu_op = 3'(op); cfg_shift_kind = 2'(k);
              cfg_amt_from_data = 1'(ad); cfg_amt_const = 5'(consts[c]);
              n = ad ? int'(bv % 32) : consts[c];
              y = model_shift(2'(k), n, model_alu(3'(op), av, bv));
              if (k != 0 && ad != 0) tag = "R7 data shift amount";
              else if (k != 0 && op < 6) tag = "R8 alu then shift";
              else if (k != 0) tag = "R6 shift kind";
              else if (op < 2) tag = "R3 add/sub";
              else if (op < 6) tag = "R4 logic op";
              else tag = "R5 bypass/zero";
              #1;
              check(tag, result, y);
            end
          end
        end
      end
    end
    cfg_amt_from_data = 1'b0;

    // Feedback register behaviour (R9, R10)
    @(negedge clk);
    cfg_alu_op = 3'd0; cfg_shift_kind = 2'd0; cfg_src_a = 2'd3; cfg_src_b = 2'd0;
    rf_b = 32'd7;
    for (int i = 0; i < 6; i++) begin
      step_en = (i % 2 == 0);
      @(negedge clk);
      if (i % 2 == 0) q_model = q_model + 32'd7;
      check(i % 2 == 0 ? "R9 accumulate on enable" : "R9 hold when disabled", result_q, q_model);
    end
    step_en = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R10 reset beats enable", result_q, '0);
    rst = 1'b0; step_en = 1'b0;
    @(negedge clk);
    check("R10 stays clear", result_q, '0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule